// File: doc/BRIEF.md
# Three-Wire Serial Register Target with Seconds Counter

This block is the always-on half of a three-wire synchronous serial link. A host front end drives a serial clock, an enable line and a data-in line, and reads one data-out line. The block holds a running seconds counter, a seconds-adjust word and four general-purpose 32-bit storage words. It decodes write and read frames on the link, updates or returns the addressed word, and shows the host through a ready flag when a new frame may begin. All three host lines are low while the link is idle.

Every input from the link passes through a two-flop synchronizer and is sampled in the system clock domain. The system clock must run at least eight times faster than the serial clock. The serial clock rising edge is the only event that moves data. The tick input is a one-cycle strobe in the system clock domain that arrives once per second. The frame decoder has four states. `ST_IDLE` is the only state with ready high, and it moves to `ST_SHIFT_IN` when enable goes high. `ST_SHIFT_IN` takes in bits while enable is high, and moves to `ST_WAIT_DIR` when enable falls. In `ST_WAIT_DIR`, a clock edge carrying the direction bit does one of three things: it commits a write and returns to `ST_IDLE`, it starts a read in `ST_SEND`, or it drops a malformed frame and returns to `ST_IDLE`. If enable rises again before that edge, the state goes back to `ST_SHIFT_IN`. `ST_SEND` shifts out 32 bits and returns to `ST_IDLE` after the last one.

Top module: `rtc_serial_target`

## Requirements
- R1: A synchronous reset clears every register to zero, sets data-out low, returns the decoder to idle and leaves ready high.
- R2: Write frame. Enable is high for 32 data bits followed by 3 address bits, each sent most significant bit first and captured on a serial clock rising edge. Enable then goes low and a direction bit of 1 is clocked in. That edge writes the data to the addressed word.
- R3: Read frame. Enable is high for 3 address bits. Enable then goes low and a direction bit of 0 is clocked in. On each of the next 32 rising edges, data-out shows the next bit of the addressed word, most significant bit first.
- R4: Address 0 is the seconds counter, address 2 is the seconds-adjust word, and addresses 4, 5, 6 and 7 are four storage words. Each can be written and read back without changing the others.
- R5: Reads of addresses 1 and 3 return zero, and writes to those addresses change nothing.
- R6: Each cycle with tick high adds one to the seconds counter, and 0xFFFFFFFF wraps to 0. The counter holds its value in every other cycle unless it is written.
- R7: If a write to address 0 commits in the same cycle as a tick, the written value is stored and the tick is lost.
- R8: Ready goes low when a frame starts. It stays low until the direction bit of a write has been handled, or until the 32nd output bit of a read has been presented.
- R9: A frame whose bit count does not match its direction bit is dropped. A 1 needs 35 bits and a 0 needs 3 bits. A dropped frame changes no register, and ready returns high.
- R10: Data-out changes only in the cycle after a detected serial clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sen_i | input | 1 | Frame enable from the host, asynchronous |
| sdi_i | input | 1 | Serial data from the host, asynchronous |
| tick_i | input | 1 | One-cycle once-per-second strobe |
| sdo_o | output | 1 | Serial data to the host |
| ready_o | output | 1 | High when a new frame may start |

## Verification
The assertions check the counter rules in every cycle: it steps by one on a tick, holds without one, and takes a committed write ahead of a tick. They also check that a write commit happens only while ready is low and is followed by ready, and that data-out moves only after a detected clock edge. Some behaviour can only be shown by the bench's frames: bit ordering across the 35-bit write and the 32-bit read-out, the address map, the zero reads and ignored writes at the unmapped addresses, dropped malformed frames, the ready window, the counter wrap, and a tick placed in exactly the commit cycle.

// File: rtl/srt_pkg.sv
package srt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SHIFT_IN = 2'd1,
        ST_WAIT_DIR = 2'd2,
        ST_SEND     = 2'd3
    } srt_state_e;

    // Word locations; the host software depends on these values.
    localparam int ADR_COUNT   = 0;
    localparam int ADR_ADJUST  = 2;
    localparam int ADR_GP_BASE = 4;

endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_i[b]};
                end
            end
            assign lvl_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/srt_frame_fsm.sv
module srt_frame_fsm
    import srt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_q,
    input  logic              sen_q,
    input  logic              sdi_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              sclk_rise,
    output logic              sdo_o,
    output logic              ready_o
);
    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int OCNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  CNT_WRITE = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0]  CNT_READ  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(FRAME_W + 1);
    localparam logic [OCNT_W-1:0] OUT_LAST  = OCNT_W'(DATA_W - 1);

    srt_state_e         state, state_nx;
    logic               sclk_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] in_sr;
    logic [DATA_W-1:0]  out_sr;
    logic [OCNT_W-1:0]  out_cnt;
    logic               sdo_q;
    logic               dir_edge, go_write, go_read;

    assign sclk_rise = sclk_q & ~sclk_d;
    assign dir_edge  = (state == ST_WAIT_DIR) && !sen_q && sclk_rise;
    assign go_write  = dir_edge && sdi_q && (bit_cnt == CNT_WRITE);
    assign go_read   = dir_edge && !sdi_q && (bit_cnt == CNT_READ);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sen_q) state_nx = ST_SHIFT_IN;
            end
            ST_SHIFT_IN: begin
                if (!sen_q) state_nx = ST_WAIT_DIR;
            end
            ST_WAIT_DIR: begin
                if (sen_q)        state_nx = ST_SHIFT_IN;
                else if (go_read) state_nx = ST_SEND;
                else if (sclk_rise) state_nx = ST_IDLE;
            end
            ST_SEND: begin
                if (sclk_rise && out_cnt == OUT_LAST) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            in_sr   <= '0;
            out_sr  <= '0;
            out_cnt <= '0;
            sdo_q   <= 1'b0;
        end else begin
            sclk_d <= sclk_q;
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                end
                ST_SHIFT_IN: begin
                    if (sen_q && sclk_rise) begin
                        in_sr <= {in_sr[FRAME_W-2:0], sdi_q};
                        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_WAIT_DIR: begin
                    if (sen_q) begin
                        bit_cnt <= '0;
                    end else if (go_read) begin
                        out_sr  <= rd_data;
                        out_cnt <= '0;
                    end
                end
                ST_SEND: begin
                    if (sclk_rise) begin
                        sdo_q   <= out_sr[DATA_W-1];
                        out_sr  <= {out_sr[DATA_W-2:0], 1'b0};
                        out_cnt <= out_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        acc_addr = in_sr[ADDR_W-1:0];
        wr_data  = in_sr[FRAME_W-1:ADDR_W];
        wr_en    = go_write;
        ready_o  = (state == ST_IDLE);
        sdo_o    = sdo_q;
    end
endmodule

// File: rtl/srt_regbank.sv
module srt_regbank
    import srt_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int GP_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] cnt_val
);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADR_COUNT);
    localparam logic [ADDR_W-1:0] A_ADJ = ADDR_W'(ADR_ADJUST);

    logic [DATA_W-1:0] cnt_q, adj_q;
    logic [DATA_W-1:0] gp_q [GP_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            adj_q <= '0;
        end else begin
            if (wr_en && acc_addr == A_CNT) cnt_q <= wr_data;
            else if (tick_i)                cnt_q <= cnt_q + 1'b1;
            if (wr_en && acc_addr == A_ADJ) adj_q <= wr_data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < GP_WORDS; g++) begin : g_word
            localparam logic [ADDR_W-1:0] A_GP = ADDR_W'(ADR_GP_BASE + g);
            always_ff @(posedge clk) begin
                if (rst) begin
                    gp_q[g] <= '0;
                end else if (wr_en && acc_addr == A_GP) begin
                    gp_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (acc_addr == A_CNT) rd_data = cnt_q;
        if (acc_addr == A_ADJ) rd_data = adj_q;
        for (int k = 0; k < GP_WORDS; k++) begin
            if (acc_addr == ADDR_W'(ADR_GP_BASE + k)) rd_data = gp_q[k];
        end
    end

    assign cnt_val = cnt_q;
endmodule

// File: rtl/rtc_serial_target.sv
module rtc_serial_target #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int GP_WORDS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic sen_i,
    input  logic sdi_i,
    input  logic tick_i,
    output logic sdo_o,
    output logic ready_o
);
    logic [2:0]        lines_q;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wr_data, rd_data, cnt_val;
    logic              wr_en, sclk_rise;

    srt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sdi_i, sen_i, sclk_i}),
        .lvl_o   (lines_q)
    );

    srt_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sclk_q    (lines_q[0]),
        .sen_q     (lines_q[1]),
        .sdi_q     (lines_q[2]),
        .rd_data   (rd_data),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .sclk_rise (sclk_rise),
        .sdo_o     (sdo_o),
        .ready_o   (ready_o)
    );

    srt_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GP_WORDS(GP_WORDS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .wr_en    (wr_en),
        .acc_addr (acc_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cnt_val  (cnt_val)
    );
endmodule

// File: rtl/rtc_serial_target_chk.sv
module rtc_serial_target_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              ready_o,
    input logic              sdo_o,
    input logic              sclk_rise,
    input logic              wr_en,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] cnt_val
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (acc_addr == '0);

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ready_o);

    p_tick_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !cnt_wr) |=> cnt_val == $past(cnt_val) + 1'b1);

    p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !cnt_wr) |=> $stable(cnt_val));

    p_write_beats_tick_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_val == $past(wr_data));

    p_busy_on_commit_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ready_o);

    p_ready_after_commit_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ready_o);

    p_sdo_on_edge_r10: assert property (@(posedge clk) disable iff (rst)
        !sclk_rise |=> $stable(sdo_o));
endmodule

bind rtc_serial_target rtc_serial_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .ready_o   (ready_o),
    .sdo_o     (sdo_o),
    .sclk_rise (sclk_rise),
    .wr_en     (wr_en),
    .acc_addr  (acc_addr),
    .wr_data   (wr_data),
    .cnt_val   (cnt_val)
);

// File: tb/rtc_serial_target_bench.sv
module rtc_serial_target_bench;
    localparam int HALF = 8;
    localparam int NVEC = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sen = 1'b0, sdi = 1'b0, tick = 1'b0;
    logic sdo, ready;
    int   total = 0;
    int   bad = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    rtc_serial_target u_rtc_serial_target (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sen_i(sen), .sdi_i(sdi),
        .tick_i(tick), .sdo_o(sdo), .ready_o(ready)
    );

    // {write, addr[2:0], data[31:0]}; for reads data is the expected value
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b1, 3'd2, 32'hA5A5_0001},
        {1'b1, 3'd4, 32'h1111_0004},
        {1'b1, 3'd5, 32'h2222_0005},
        {1'b1, 3'd6, 32'h3333_0006},
        {1'b1, 3'd7, 32'h8000_0007},
        {1'b1, 3'd1, 32'hDEAD_BEEF},
        {1'b1, 3'd3, 32'hCAFE_F00D},
        {1'b1, 3'd0, 32'h1234_5678},
        {1'b0, 3'd0, 32'h1234_5678},
        {1'b0, 3'd2, 32'hA5A5_0001},
        {1'b0, 3'd4, 32'h1111_0004},
        {1'b0, 3'd5, 32'h2222_0005},
        {1'b0, 3'd6, 32'h3333_0006},
        {1'b0, 3'd7, 32'h8000_0007},
        {1'b0, 3'd1, 32'h0000_0000},
        {1'b0, 3'd3, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse();
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic go_idle();
        sclk = 1'b0; sen = 1'b0; sdi = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // Sends n bits MSB first, then the direction bit with enable low.
    task automatic send_frame(input logic [34:0] bits, input int n, input logic dir,
                              input bit chk_busy, input bit tick_at_dir);
        while (!ready) @(negedge clk);
        sen = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            pulse();
            if (chk_busy && i == n - 1) check("R8 busy in frame", {31'b0, ready}, 32'd0);
        end
        sen = 1'b0;
        sdi = 1'b0;
        repeat (HALF) @(negedge clk);
        sdi = dir;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        if (tick_at_dir) begin
            @(negedge clk);
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (HALF - 3) @(negedge clk);
        end else begin
            repeat (HALF) @(negedge clk);
        end
        sdi = 1'b0;
    endtask

    task automatic write_word(input logic [2:0] a, input logic [31:0] d);
        send_frame({d, a}, 35, 1'b1, 1'b0, 1'b0);
        go_idle();
    endtask

    task automatic read_word(input logic [2:0] a, input bit chk_ready, output logic [31:0] d);
        d = '0;
        send_frame({32'b0, a}, 3, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 32; k++) begin
            if (chk_ready && k == 31) check("R8 busy before last read bit", {31'b0, ready}, 32'd0);
            pulse();
            d = {d[30:0], sdo};
        end
        if (chk_ready) check("R8 ready after last read bit", {31'b0, ready}, 32'd1);
        go_idle();
    endtask

    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 ready after reset", {31'b0, ready}, 32'd1);
        check("R1 sdo after reset", {31'b0, sdo}, 32'd0);
        read_word(3'd0, 1'b0, rd); check("R1 counter cleared", rd, 32'd0);
        read_word(3'd7, 1'b0, rd); check("R1 storage cleared", rd, 32'd0);

        // Vector table: R2 writes, R3/R4 reads, R5 unmapped
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][35]) begin
                write_word(VEC[v][34:32], VEC[v][31:0]);
            end else begin
                read_word(VEC[v][34:32], 1'b0, rd);
                if (VEC[v][34:32] == 3'd1 || VEC[v][34:32] == 3'd3)
                    check("R5 unmapped reads zero", rd, VEC[v][31:0]);
                else
                    check("R2 R3 R4 readback", rd, VEC[v][31:0]);
            end
        end

        // R8 ready window on write and read
        send_frame({32'h0F0F_F0F0, 3'd4}, 35, 1'b1, 1'b1, 1'b0);
        check("R8 ready after write commit", {31'b0, ready}, 32'd1);
        go_idle();
        read_word(3'd4, 1'b1, rd);
        check("R2 overwrite readback", rd, 32'h0F0F_F0F0);

        // R9 malformed frames: 3 bits with dir 1, 35 bits with dir 0
        send_frame({32'b0, 3'd5}, 3, 1'b1, 1'b0, 1'b0);
        check("R9 ready after short write", {31'b0, ready}, 32'd1);
        go_idle();
        send_frame({32'hFFFF_FFFF, 3'd5}, 35, 1'b0, 1'b0, 1'b0);
        check("R9 ready after long read", {31'b0, ready}, 32'd1);
        go_idle();
        read_word(3'd5, 1'b0, rd);
        check("R9 word unchanged", rd, 32'h2222_0005);

        // R6 tick counting and wrap
        write_word(3'd0, 32'h0000_0010);
        tick_once(); tick_once(); tick_once();
        read_word(3'd0, 1'b0, rd);
        check("R6 three ticks", rd, 32'h0000_0013);
        write_word(3'd0, 32'hFFFF_FFFF);
        tick_once();
        read_word(3'd0, 1'b0, rd);
        check("R6 wrap to zero", rd, 32'h0000_0000);

        // R7 write takes priority over a tick in the commit cycle
        send_frame({32'h0000_0777, 3'd0}, 35, 1'b1, 1'b0, 1'b1);
        go_idle();
        read_word(3'd0, 1'b0, rd);
        check("R7 write beats tick", rd, 32'h0000_0777);

        // R10 data-out holds while idle after a read
        begin
            logic held;
            held = sdo;
            repeat (20) @(negedge clk);
            check("R10 sdo stable without edges", {31'b0, sdo}, {31'b0, held});
        end

        // R1 reset mid-operation clears registers
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);
        read_word(3'd2, 1'b0, rd);
        check("R1 adjust cleared by reset", rd, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule